// File: doc/BRIEF.md
# Gated Triggered Pattern Output Stage

This block is the last stage of a pattern player. It pulls pre-decoded pattern elements from a FIFO-style source and turns them into a parallel output bus. It also drives a sample qualifier, a strobe that is high only in the low half of the output clock, and a completion flag. Each element carries a value and a two-bit kind. The kind says whether the element is an ordinary sample, a sample that must not be strobed, the last element of the pattern, or a point where playback waits for a fresh trigger.

Elements are consumed only when three things hold: an external trigger has armed the stage, the pacing gate is open, and the source is not empty. While the stage is paused, the bus keeps its last value and the qualifier stays low. When a retrigger element is consumed, the stage disarms itself. It then raises a reset request toward the trigger logic for as long as that logic still reports a trigger. Playback continues with the next element once a new trigger arrives.

Top module: `pattern_out_stage`

## Requirements
- R1: After a synchronous reset, `dataOut` is 0, `sampleValid`, `sampleStrobe` and `finished` are low, and `elemRead` is low.
- R2: `elemRead` is high only when the stage is armed by a trigger, `gateOpen` is high, `elemEmpty` is low and `finished` is low.
- R3: Reading a kind 2'b00 (plain sample) element loads its value into `dataOut` on that clock edge and makes `sampleValid` high for the following cycle.
- R4: `sampleStrobe` is high only while the clock is low and `sampleValid` is high.
- R5: Reading a kind 2'b01 (unstrobed sample) element loads its value into `dataOut`, and neither `sampleValid` nor `sampleStrobe` rises.
- R6: Reading a kind 2'b10 (last) element loads its value into `dataOut` and raises `finished` on the same edge, with `sampleValid` low.
- R7: While `gateOpen` is low, no element is read, `dataOut` holds and `sampleValid` stays low. Once the gate reopens, playback resumes with the next unread element.
- R8: A trigger that arrives while the gate is closed arms the stage, but `dataOut` does not advance until the gate opens.
- R9: Reading a kind 2'b11 (retrigger) element leaves `dataOut` unchanged and stops further reads. `trigReset` is then high while `trigFire` stays high. After `trigFire` has dropped and fires again, reading resumes with the element that follows.
- R10: `finished` stays high until reset, and no element is read while it is high.
- R11: While `elemEmpty` is high, no element is read and the outputs hold, just as with a closed gate. Playback starts on the edge after an element becomes available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock |
| rst | input | 1 | Synchronous reset, active high |
| elemData | input | 32 | Value of the element at the head of the source |
| elemKind | input | 2 | Kind of the head element: 00 sample, 01 unstrobed, 10 last, 11 retrigger |
| elemEmpty | input | 1 | Source has no element |
| elemRead | output | 1 | Pops the head element on the rising edge |
| gateOpen | input | 1 | Pacing gate; reads are allowed while high |
| trigFire | input | 1 | Trigger output of the trigger logic |
| trigReset | output | 1 | Request to reset the trigger logic after a retrigger element |
| dataOut | output | 32 | Output bus |
| sampleValid | output | 1 | Marks a plain sample on `dataOut` |
| sampleStrobe | output | 1 | Low-phase strobe for plain samples |
| finished | output | 1 | Pattern completed |

## Verification
The hardest case to reach is the retrigger handshake. A retrigger element has to be consumed while the trigger is still reported. The reset request must be seen, the trigger must then drop, and it must fire again after the pending state has cleared. The bench holds `trigFire` high through the retrigger read and checks `trigReset` on the cycle after it. It then lowers the trigger, waits several cycles while confirming that nothing is read, and fires again so that the stage can resume with the following element. A trigger that arrives while the gate is closed and a source that starts empty are each set up by holding the relevant input for several cycles before releasing it.

// File: rtl/pattern_out_pkg.sv
package pattern_out_pkg;

  typedef enum logic [1:0] {
    KIND_SAMPLE  = 2'b00,
    KIND_QUIET   = 2'b01,
    KIND_LAST    = 2'b10,
    KIND_REARM   = 2'b11
  } elemKindT;

  // strobes from control to datapath
  typedef struct packed {
    logic loadBus;   // capture element value on dataOut
    logic markValid; // qualify the captured value as a sample
  } outCtrlT;

endpackage

// File: rtl/pattern_out_ctrl.sv
module pattern_out_ctrl
  import pattern_out_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic [1:0] elemKind,
  input  logic     elemEmpty,
  input  logic     gateOpen,
  input  logic     trigFire,
  output logic     elemRead,
  output logic     trigReset,
  output logic     finished,
  output outCtrlT  ctrl
);

  logic trigActive;
  logic rearmPending;
  elemKindT kindNow;

  assign kindNow   = elemKindT'(elemKind);
  assign elemRead  = trigActive && gateOpen && !elemEmpty && !finished;
  assign trigReset = rearmPending && trigFire;

  always_comb begin
    ctrl.loadBus   = elemRead && (kindNow != KIND_REARM);
    ctrl.markValid = elemRead && (kindNow == KIND_SAMPLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trigActive   <= 1'b0;
      rearmPending <= 1'b0;
      finished     <= 1'b0;
    end else begin
      if (elemRead && kindNow == KIND_REARM) begin
        trigActive   <= 1'b0;
        rearmPending <= 1'b1;
      end else begin
        if (trigFire && !rearmPending) trigActive <= 1'b1;
        if (!trigFire) rearmPending <= 1'b0;
      end
      if (elemRead && kindNow == KIND_LAST) finished <= 1'b1;
    end
  end

endmodule

// File: rtl/pattern_out_dp.sv
module pattern_out_dp
  import pattern_out_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  outCtrlT       ctrl,
  input  logic [DW-1:0] elemData,
  output logic [DW-1:0] dataOut,
  output logic          sampleValid,
  output logic          sampleStrobe
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dataOut     <= '0;
      sampleValid <= 1'b0;
    end else begin
      if (ctrl.loadBus) dataOut <= elemData;
      sampleValid <= ctrl.markValid;
    end
  end

  // strobe lives in the low half of the clock
  assign sampleStrobe = sampleValid && !clk;

endmodule

// File: rtl/pattern_out_stage.sv
module pattern_out_stage
  import pattern_out_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] elemData,
  input  logic [1:0]    elemKind,
  input  logic          elemEmpty,
  output logic          elemRead,
  input  logic          gateOpen,
  input  logic          trigFire,
  output logic          trigReset,
  output logic [DW-1:0] dataOut,
  output logic          sampleValid,
  output logic          sampleStrobe,
  output logic          finished
);

  outCtrlT ctrl;

  pattern_out_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .elemKind  (elemKind),
    .elemEmpty (elemEmpty),
    .gateOpen  (gateOpen),
    .trigFire  (trigFire),
    .elemRead  (elemRead),
    .trigReset (trigReset),
    .finished  (finished),
    .ctrl      (ctrl)
  );

  pattern_out_dp #(.DW(DW)) u_dp (
    .clk          (clk),
    .rst          (rst),
    .ctrl         (ctrl),
    .elemData     (elemData),
    .dataOut      (dataOut),
    .sampleValid  (sampleValid),
    .sampleStrobe (sampleStrobe)
  );

endmodule

// File: rtl/pattern_out_checks.sv
module pattern_out_checks #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] elemData,
  input logic [1:0]    elemKind,
  input logic          elemEmpty,
  input logic          elemRead,
  input logic          gateOpen,
  input logic          trigFire,
  input logic          trigReset,
  input logic [DW-1:0] dataOut,
  input logic          sampleValid,
  input logic          finished
);

  a_r2_read_needs_gate: assert property (@(posedge clk) disable iff (rst)
    elemRead |-> (gateOpen && !elemEmpty && !finished));

  a_r3_sample_loads: assert property (@(posedge clk) disable iff (rst)
    (elemRead && elemKind == 2'b00) |=> (sampleValid && dataOut == $past(elemData)));

  a_r5_quiet_loads: assert property (@(posedge clk) disable iff (rst)
    (elemRead && elemKind == 2'b01) |=> (!sampleValid && dataOut == $past(elemData)));

  a_r6_last_done: assert property (@(posedge clk) disable iff (rst)
    (elemRead && elemKind == 2'b10) |=> (finished && !sampleValid && dataOut == $past(elemData)));

  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !elemRead |=> ($stable(dataOut) && !sampleValid));

  a_r9_rearm_holds_bus: assert property (@(posedge clk) disable iff (rst)
    (elemRead && elemKind == 2'b11) |=> ($stable(dataOut) && !elemRead));

  a_r10_done_sticky: assert property (@(posedge clk) disable iff (rst)
    finished |=> finished);

endmodule

bind pattern_out_stage pattern_out_checks #(.DW(DW)) u_checks (
  .clk(clk), .rst(rst), .elemData(elemData), .elemKind(elemKind),
  .elemEmpty(elemEmpty), .elemRead(elemRead), .gateOpen(gateOpen),
  .trigFire(trigFire), .trigReset(trigReset), .dataOut(dataOut),
  .sampleValid(sampleValid), .finished(finished)
);

// File: tb/sim_pattern_out_stage.sv
`timescale 1ns/1ps
module sim_pattern_out_stage;

  localparam int DW = 32;
  localparam int QD = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gateOpen = 1'b0;
  logic trigFire = 1'b0;
  logic [DW-1:0] dataQ [QD];
  logic [1:0]    kindQ [QD];
  int wrIdx = 0;
  int rdIdx = 0;

  logic [DW-1:0] elemData;
  logic [1:0]    elemKind;
  logic elemEmpty, elemRead, trigReset, sampleValid, sampleStrobe, finished;
  logic [DW-1:0] dataOut;

  int nRun = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  assign elemEmpty = (rdIdx == wrIdx);
  assign elemData  = dataQ[rdIdx % QD];
  assign elemKind  = kindQ[rdIdx % QD];

  always @(posedge clk) begin
    if (rst) rdIdx <= 0;
    else if (elemRead) rdIdx <= rdIdx + 1;
  end

  pattern_out_stage #(.DW(DW)) u0 (
    .clk(clk), .rst(rst), .elemData(elemData), .elemKind(elemKind),
    .elemEmpty(elemEmpty), .elemRead(elemRead), .gateOpen(gateOpen),
    .trigFire(trigFire), .trigReset(trigReset), .dataOut(dataOut),
    .sampleValid(sampleValid), .sampleStrobe(sampleStrobe), .finished(finished)
  );

  task automatic push(input logic [1:0] k, input logic [DW-1:0] d);
    dataQ[wrIdx % QD] = d;
    kindQ[wrIdx % QD] = k;
    wrIdx = wrIdx + 1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; gateOpen = 1'b0; trigFire = 1'b0; wrIdx = 0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  // waits for next falling edge, then checks outputs (clock low: strobe == valid)
  task automatic chk(input logic [DW-1:0] d, input logic v, input logic dn, input string tag);
    @(negedge clk); #1;
    nRun++;
    if (dataOut !== d || sampleValid !== v || finished !== dn || sampleStrobe !== v) begin
      nFail++;
      $display("FAIL %s: data=%h valid=%b strobe=%b done=%b, expected data=%h valid=%b strobe=%b done=%b",
               tag, dataOut, sampleValid, sampleStrobe, finished, d, v, v, dn);
    end
  endtask

  task automatic chkBit(input logic act, input logic exp, input string tag);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic testReset();
    doReset();
    #1;
    nRun++;
    if (dataOut !== '0 || sampleValid !== 1'b0 || sampleStrobe !== 1'b0 ||
        finished !== 1'b0 || elemRead !== 1'b0) begin
      nFail++;
      $display("FAIL R1: data=%h valid=%b strobe=%b done=%b read=%b, expected all zero",
               dataOut, sampleValid, sampleStrobe, finished, elemRead);
    end
  endtask

  task automatic testBasic();
    doReset();
    push(2'b00, 32'h11); push(2'b00, 32'h22); push(2'b01, 32'h55);
    push(2'b10, 32'hcc); push(2'b00, 32'hee);
    gateOpen = 1'b1; trigFire = 1'b1;
    chk(32'h0, 0, 0, "R2 armed next edge");
    chk(32'h11, 1, 0, "R3 first sample");
    // clock high after the next rising edge: valid stays high, strobe must be low
    @(posedge clk); #1;
    chkBit(sampleValid, 1'b1, "R4 valid in high phase");
    chkBit(sampleStrobe, 1'b0, "R4 strobe low in high phase");
    chk(32'h22, 1, 0, "R3 second sample");
    chk(32'h55, 0, 0, "R5 unstrobed sample");
    chk(32'hcc, 0, 1, "R6 last element");
    chk(32'hcc, 0, 1, "R10 done holds");
    chk(32'hcc, 0, 1, "R10 no read after done");
    chkBit(elemRead, 1'b0, "R10 read low after done");
    testReset();
  endtask

  task automatic testGate();
    doReset();
    push(2'b00, 32'h11); push(2'b00, 32'h22); push(2'b10, 32'h33);
    trigFire = 1'b1;
    chk(32'h0, 0, 0, "R8 closed gate 1");
    chk(32'h0, 0, 0, "R8 closed gate 2");
    chkBit(elemRead, 1'b0, "R8 no read with gate closed");
    gateOpen = 1'b1;
    chk(32'h11, 1, 0, "R8 advance after gate opens");
    gateOpen = 1'b0;
    chk(32'h11, 0, 0, "R7 hold while closed 1");
    chk(32'h11, 0, 0, "R7 hold while closed 2");
    gateOpen = 1'b1;
    chk(32'h22, 1, 0, "R7 resume with next element");
    chk(32'h33, 0, 1, "R7 final after resume");
  endtask

  task automatic testEmpty();
    doReset();
    push(2'b00, 32'h77);
    gateOpen = 1'b1; trigFire = 1'b1;
    chk(32'h0, 0, 0, "R11 armed");
    chk(32'h77, 1, 0, "R11 first element");
    chk(32'h77, 0, 0, "R11 hold while empty 1");
    chk(32'h77, 0, 0, "R11 hold while empty 2");
    chkBit(elemRead, 1'b0, "R11 no read while empty");
    push(2'b00, 32'h78);
    chk(32'h78, 1, 0, "R11 resume when available");
  endtask

  task automatic testRearm();
    doReset();
    push(2'b00, 32'h12345678); push(2'b11, 32'hdeadbeef);
    push(2'b00, 32'h87654321); push(2'b10, 32'h0badf00d);
    gateOpen = 1'b1; trigFire = 1'b1;
    chk(32'h0, 0, 0, "R9 armed");
    chk(32'h12345678, 1, 0, "R9 first burst");
    chk(32'h12345678, 0, 0, "R9 rearm element holds bus");
    chkBit(trigReset, 1'b1, "R9 reset request while trigger high");
    chkBit(elemRead, 1'b0, "R9 paused after rearm");
    trigFire = 1'b0;
    chk(32'h12345678, 0, 0, "R9 wait 1");
    chkBit(trigReset, 1'b0, "R9 request drops with trigger");
    chk(32'h12345678, 0, 0, "R9 wait 2");
    chk(32'h12345678, 0, 0, "R9 wait 3");
    trigFire = 1'b1;
    chk(32'h12345678, 0, 0, "R9 rearming");
    chk(32'h87654321, 1, 0, "R9 second burst");
    chk(32'h0badf00d, 0, 1, "R9 final after rearm");
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    nRun++; nFail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < QD; i++) begin dataQ[i] = '0; kindQ[i] = 2'b00; end
    testReset();
    testBasic();
    testGate();
    testEmpty();
    testRearm();
    finishRun();
  end

endmodule